// File: doc/BRIEF.md
# Leaky-Bucket Hit Rate Limiter

This block qualifies the hit strobe of one time-to-digital channel before the hit enters the data path. It runs on the fast sampling clock and keeps a credit level. Every accepted hit raises the level by a fixed step. Every cycle without an accepted hit lowers it by one, and the level never drops below zero. A hit that arrives while the level is at or above the threshold is dropped. The default step of 32 and threshold of 224 give a burst allowance of seven hits. They also cap the sustained rate without dead time at one hit every 33 cycles.

A synchronous clear, pulsed at the start of each spill, empties the level and the count of dropped hits. The qualified strobe and the drop count are registered, so both reflect a hit one clock after it is presented. The drop count is a saturating counter that sits with the limiter.

Top module: `hit_rate_limiter`

## Requirements
- R1: A hit presented while the level is below THRESH (default 224) is passed. `hit_out` is high exactly one cycle later, and the level rises by STEP (default 32).
- R2: A hit presented while the level is at or above THRESH is dropped. `hit_out` stays low one cycle later, and the level falls by one instead of rising.
- R3: On a cycle with no hit and no clear, the level falls by one. When the level is already zero, it stays at zero.
- R4: Each dropped hit raises `drop_cnt` by one in the following cycle. The count saturates at 2^CNT_W-1 (65535 by default) and does not wrap.
- R5: When `spill_clr` is high, the next cycle shows a level of zero, a `drop_cnt` of zero and a low `hit_out`. This holds even if a hit is presented in the same cycle. The clear takes priority over any hit.
- R6: While `rst_n` is low and after it is released, `hit_out` is low and `drop_cnt` is zero until a hit arrives.
- R7: Starting from an empty level, a train of back-to-back hits passes exactly seven hits, and the eighth hit is dropped.
- R8: A hit every 33 cycles is never dropped, however long the train lasts.
- R9: Under continuous hits, no window of 256 consecutive cycles contains more than 15 passed hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_clr | input | 1 | Synchronous clear at spill start |
| hit_in | input | 1 | Raw hit-valid strobe from the front end |
| hit_out | output | 1 | Qualified hit-valid, one cycle after hit_in |
| drop_cnt | output | CNT_W (16) | Saturating count of dropped hits |

## Verification
The bench targets three edges: the exact threshold crossing, the empty floor and the point where the drop count saturates. If the comparison is off by one, the seventh or eighth hit of a burst comes out wrong. If the floor is missing, an idle level wraps to its maximum and blocks a long run of hits. If the counter wraps, the count reads 0 after 65535 drops. A clear that arrives together with a hit, and a hit every 33 cycles, are also driven. Clear priority is checked on the first case. The second case exposes a drain that runs one step too slow. Random hit trains are compared cycle by cycle against an arithmetic model of the level.

// File: rtl/hrl_pkg.sv
package hrl_pkg;

    localparam int DEF_STEP   = 32;
    localparam int DEF_THRESH = 224;
    localparam int DEF_CNT_W  = 16;

    // Outcome of one clock for the bucket, consumed by the drop counter.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_PASS  = 2'd1,
        ACT_DROP  = 2'd2,
        ACT_CLEAR = 2'd3
    } hrl_act_e;

endpackage

// File: rtl/hrl_bucket.sv
module hrl_bucket
    import hrl_pkg::*;
#(
    parameter int STEP   = DEF_STEP,
    parameter int THRESH = DEF_THRESH,
    parameter int ACC_W  = $clog2(THRESH + STEP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spill_clr,
    input  logic             hit_in,
    output logic             pass_q_o,
    output hrl_act_e         act_o,
    output logic [ACC_W-1:0] level_o
);

    localparam logic [ACC_W-1:0] STEP_V   = ACC_W'(STEP);
    localparam logic [ACC_W-1:0] THRESH_V = ACC_W'(THRESH);
    localparam logic [ACC_W-1:0] ONE_V    = ACC_W'(1);

    typedef struct packed {
        logic [ACC_W-1:0] level;
        logic             pass;
    } bucket_t;

    bucket_t  st_d, st_q;
    hrl_act_e act_d;
    logic     under_thr;

    assign under_thr = (st_q.level < THRESH_V);

    always_comb begin
        st_d      = st_q;
        st_d.pass = 1'b0;
        act_d     = ACT_IDLE;
        if (spill_clr) begin
            st_d.level = '0;
            act_d      = ACT_CLEAR;
        end else if (hit_in) begin
            if (under_thr) begin
                st_d.level = st_q.level + STEP_V;
                st_d.pass  = 1'b1;
                act_d      = ACT_PASS;
            end else begin
                st_d.level = st_q.level - ONE_V;
                act_d      = ACT_DROP;
            end
        end else if (st_q.level != '0) begin
            st_d.level = st_q.level - ONE_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pass_q_o = st_q.pass;
    assign act_o    = act_d;
    assign level_o  = st_q.level;

endmodule

// File: rtl/hrl_drop_counter.sv
module hrl_drop_counter
    import hrl_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hrl_act_e         act_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (act_i)
            ACT_CLEAR: cnt_d.count = '0;
            ACT_DROP: begin
                if (cnt_q.count != CNT_MAX) begin
                    cnt_d.count = cnt_q.count + ONE_C;
                end
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.count;

endmodule

// File: rtl/hit_rate_limiter.sv
module hit_rate_limiter
    import hrl_pkg::*;
#(
    parameter int STEP   = DEF_STEP,
    parameter int THRESH = DEF_THRESH,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spill_clr,
    input  logic             hit_in,
    output logic             hit_out,
    output logic [CNT_W-1:0] drop_cnt
);

    localparam int ACC_W = $clog2(THRESH + STEP + 1);

    hrl_act_e         bucket_act;
    logic [ACC_W-1:0] acc_level;

    hrl_bucket #(
        .STEP   (STEP),
        .THRESH (THRESH),
        .ACC_W  (ACC_W)
    ) u_bucket (
        .clk       (clk),
        .rst_n     (rst_n),
        .spill_clr (spill_clr),
        .hit_in    (hit_in),
        .pass_q_o  (hit_out),
        .act_o     (bucket_act),
        .level_o   (acc_level)
    );

    hrl_drop_counter #(
        .CNT_W (CNT_W)
    ) u_drops (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (bucket_act),
        .count_o (drop_cnt)
    );

endmodule

// File: rtl/hrl_checker.sv
module hrl_checker #(
    parameter int STEP   = 32,
    parameter int THRESH = 224,
    parameter int CNT_W  = 16,
    parameter int ACC_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spill_clr,
    input logic             hit_in,
    input logic             hit_out,
    input logic [CNT_W-1:0] drop_cnt,
    input logic [ACC_W-1:0] level
);

    localparam logic [ACC_W-1:0] STEP_V   = ACC_W'(STEP);
    localparam logic [ACC_W-1:0] THRESH_V = ACC_W'(THRESH);
    localparam logic [ACC_W-1:0] TOP_V    = ACC_W'(THRESH - 1 + STEP);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= TOP_V);

    assert_pass_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_in && !spill_clr && level < THRESH_V) |=> (hit_out && level == $past(level) + STEP_V));

    assert_drop_lowers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_in && !spill_clr && level >= THRESH_V) |=> (!hit_out && level == $past(level) - 1'b1));

    assert_empty_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_in && !spill_clr && level == '0) |=> (level == '0 && !hit_out));

    assert_drop_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_in && !spill_clr && level >= THRESH_V && drop_cnt != CNT_MAX)
        |=> drop_cnt == $past(drop_cnt) + 1'b1);

    assert_count_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spill_clr && !(hit_in && level >= THRESH_V)) |=> $stable(drop_cnt));

    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spill_clr |=> (level == '0 && drop_cnt == '0 && !hit_out));

endmodule

bind hit_rate_limiter hrl_checker #(
    .STEP   (STEP),
    .THRESH (THRESH),
    .CNT_W  (CNT_W),
    .ACC_W  (ACC_W)
) u_hrl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .spill_clr (spill_clr),
    .hit_in    (hit_in),
    .hit_out   (hit_out),
    .drop_cnt  (drop_cnt),
    .level     (acc_level)
);

// File: tb/hit_rate_limiter_bench.sv
module hit_rate_limiter_bench;

    localparam int STEP   = 32;
    localparam int THRESH = 224;
    localparam int CNT_W  = 16;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int WIN    = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             spill_clr = 1'b0;
    logic             hit_in = 1'b0;
    logic             hit_out;
    logic [CNT_W-1:0] drop_cnt;

    int checks = 0;
    int errors = 0;
    int m_acc = 0;
    int m_cnt = 0;
    int pass_seen = 0;
    bit win_hist [WIN];
    int win_idx = 0;
    int win_sum = 0;
    int win_max = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hit_rate_limiter #(
        .STEP   (STEP),
        .THRESH (THRESH),
        .CNT_W  (CNT_W)
    ) u_hit_rate_limiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .spill_clr (spill_clr),
        .hit_in    (hit_in),
        .hit_out   (hit_out),
        .drop_cnt  (drop_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic win_reset();
        for (int i = 0; i < WIN; i++) win_hist[i] = 1'b0;
        win_idx = 0;
        win_sum = 0;
        win_max = 0;
    endtask

    // One clock: drive at negedge, model the edge, compare 5 ns after it.
    task automatic step(input logic h, input logic c);
        int    e_out;
        string tag;
        @(negedge clk);
        hit_in    = h;
        spill_clr = c;
        if (c) begin
            m_acc = 0; m_cnt = 0; e_out = 0; tag = "R5";
        end else if (h && m_acc < THRESH) begin
            m_acc += STEP; e_out = 1; tag = "R1";
        end else if (h) begin
            m_acc -= 1; e_out = 0;
            if (m_cnt < CMAX) m_cnt++;
            tag = (m_cnt == CMAX) ? "R4" : "R2";
        end else begin
            if (m_acc > 0) m_acc -= 1;
            e_out = 0; tag = "R3";
        end
        @(posedge clk);
        #5;
        check(tag, int'(hit_out), e_out);
        check("R4", int'(drop_cnt), m_cnt);
        if (hit_out) pass_seen++;
        win_sum = win_sum - int'(win_hist[win_idx]) + int'(hit_out);
        win_hist[win_idx] = hit_out;
        win_idx = (win_idx + 1) % WIN;
        if (win_sum > win_max) win_max = win_sum;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset state, with a hit presented during reset
        hit_in = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        check("R6", int'(hit_out), 0);
        check("R6", int'(drop_cnt), 0);
        @(negedge clk);
        hit_in = 1'b0;
        rst_n  = 1'b1;
        @(posedge clk); #5;
        check("R6", int'(hit_out), 0);
        check("R6", int'(drop_cnt), 0);

        // R7: burst from empty, seven pass, eighth dropped
        step(1'b0, 1'b1);
        pass_seen = 0;
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        check("R7", pass_seen, 7);
        step(1'b1, 1'b0);
        check("R7", int'(hit_out), 0);
        check("R7", int'(drop_cnt), 1);

        // R3: long idle drains to the floor, then the next hit passes
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        check("R3", int'(hit_out), 1);

        // R5: clear together with a hit
        step(1'b1, 1'b1);
        check("R5", int'(hit_out), 0);
        check("R5", int'(drop_cnt), 0);

        // R8: one hit every 33 cycles, never dropped
        step(1'b0, 1'b1);
        pass_seen = 0;
        for (int k = 0; k < 200; k++) begin
            step(1'b1, 1'b0);
            for (int j = 0; j < 32; j++) step(1'b0, 1'b0);
        end
        check("R8", pass_seen, 200);
        check("R8", int'(drop_cnt), 0);

        // R2: one hit every 32 cycles eventually gets dropped
        step(1'b0, 1'b1);
        for (int k = 0; k < 260; k++) begin
            step(1'b1, 1'b0);
            for (int j = 0; j < 31; j++) step(1'b0, 1'b0);
        end
        check("R2", int'(drop_cnt > 0), 1);

        // Random trains with occasional clears
        for (int k = 0; k < 20000; k++) begin
            step(1'b1 && ($urandom_range(0, 99) < 6), ($urandom_range(0, 4999) == 0));
        end

        // R9 and R4 saturation: continuous hits after a clear
        step(1'b0, 1'b1);
        win_reset();
        for (int k = 0; k < 70000; k++) step(1'b1, 1'b0);
        check("R9", int'(win_max <= 15), 1);
        check("R4", int'(drop_cnt), CMAX);
        step(1'b1, 1'b0);
        check("R4", int'(drop_cnt), CMAX);

        // R5: clear after saturation
        step(1'b0, 1'b1);
        check("R5", int'(drop_cnt), 0);
        step(1'b1, 1'b0);
        check("R1", int'(hit_out), 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule